// File: doc/BRIEF.md
# Two-Wire Register-File Slave

This block is a two-wire serial bus slave that exposes a small bank of byte-wide control registers to an external bus master. The bus clock and data lines are sampled with the system clock. Start, repeated-start and stop conditions are recognised from the sampled levels. A transfer is accepted only when the 7-bit device address matches. The upper six address bits are a parameter. The lowest bit follows a strap pin, so two copies can sit on one bus.

In a write transfer, the first byte after the device address selects a register base. Every further byte is stored at the current register pointer, and the pointer then steps forward. A read transfer returns bytes from the pointer left by the most recent base write. The usual sequence is a write of the base only, a repeated start, and then a read. The pointer holds at the highest register instead of wrapping. A base beyond the bank is refused.

The block never drives the data line high. It provides a pull-low enable that the pad logic turns into an open-drain driver. The register contents are presented in parallel to the surrounding chip.

Top module: `i2c_regfile_slave`

## Requirements
- R1: After reset every register reads 0x00, the pull-low enable is inactive and the register pointer is 0.
- R2: The device address is the parameter DEV_ADDR_HI (default 6'b101101) in bits 6..1 and the strap input in bit 0, sent MSB first and followed by a direction bit (1 = read, 0 = write). On a match, the slave holds SDA low during the ninth SCL pulse.
- R3: On a device-address mismatch the slave gives no acknowledge. It then leaves SDA released and changes no register until the next start.
- R4: In a write, the byte after the device address sets the pointer (and is acknowledged). Each following byte is written to the pointer, which then advances by one.
- R5: The pointer never passes the last register, index NUM_REGS-1 (0x19 by default). Surplus write bytes all land in that register.
- R6: A base byte above NUM_REGS-1 is not acknowledged and leaves the pointer unchanged. Later bytes of that transfer are neither acknowledged nor stored.
- R7: A read returns, MSB first, the register at the pointer and then the following registers. It may be entered through a repeated start, or through a fresh start that keeps the pointer from an earlier transfer.
- R8: Reads past the last register keep returning the last register.
- R9: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing until the next start or stop.
- R10: A start inside a byte discards the partial byte and restarts device-address reception. A stop inside a byte returns the slave to idle. Registers already written keep their values.
- R11: The pull-low enable changes only after a falling SCL edge, or on a start or stop, so it never changes while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock level from the bus |
| sda_i | input | 1 | Serial data level from the bus |
| addr_sel_i | input | 1 | Strap for device-address bit 0 |
| sda_pull_o | output | 1 | High to pull SDA low (open-drain enable) |
| regs_o | output | NUM_REGS*8 | All register bytes, register k in bits 8k+7..8k |

## Verification
Every line edge passes through two synchroniser flops, and its edge pulse is acted on at the next clock. As a result, a register written by the eighth rising SCL edge of a data byte shows on `regs_o` three clock cycles after the bench raises SCL. The pull-low enable changes three cycles after SCL falls. The bench keeps a queue of pending register writes, each due exactly three cycles after the matching SCL rise, and compares the whole register bank against its model on every clock. Acknowledge and read-data bits are sampled halfway through the SCL high phase, well after the slave's output has settled. On every clock the bench also checks that the pull-low enable never changes while SCL is high.

// File: rtl/i2c_regfile_pkg.sv
package i2c_regfile_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_BASE,
      ST_BASE_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_TX,
      ST_TX_ACK,
      ST_SKIP
   } rf_state_e;

   localparam int BYTE_W = 8;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic sda_lvl,
   output logic start_det,
   output logic stop_det
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_q;
   logic              sda_q;
   logic              scl_s;
   logic              sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_q    <= scl_s;
         sda_q    <= sda_s;
      end
   end

   assign scl_s     = scl_pipe[STAGES-1];
   assign sda_s     = sda_pipe[STAGES-1];
   assign sda_lvl   = sda_s;
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_regfile_bank.sv
module i2c_regfile_bank #(
   parameter int NUM_REGS = 26,
   parameter int PTR_W    = $clog2(NUM_REGS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [PTR_W-1:0]      wr_idx,
   input  logic [7:0]            wr_byte,
   input  logic [PTR_W-1:0]      rd_idx,
   output logic [7:0]            rd_byte,
   output logic [NUM_REGS*8-1:0] regs_flat
);

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_cell
         logic [7:0] cell_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cell_q <= '0;
            end else if (wr_en && wr_idx == PTR_W'(g)) begin
               cell_q <= wr_byte;
            end
         end
         assign regs_flat[g*8 +: 8] = cell_q;
      end
   endgenerate

   always_comb begin
      rd_byte = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (rd_idx == PTR_W'(i)) rd_byte = regs_flat[i*8 +: 8];
      end
   end

   // R5: the write index handed over by the protocol engine stays in the bank
   assert_wr_idx_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_idx) < NUM_REGS));

endmodule

// File: rtl/i2c_regfile_fsm.sv
module i2c_regfile_fsm
   import i2c_regfile_pkg::*;
#(
   parameter int           NUM_REGS    = 26,
   parameter int           PTR_W       = $clog2(NUM_REGS),
   parameter logic [5:0]   DEV_ADDR_HI = 6'b101101
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strap_i,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             sda_lvl,
   input  logic             start_det,
   input  logic             stop_det,
   input  logic [7:0]       rd_byte,
   output logic             wr_en,
   output logic [PTR_W-1:0] wr_idx,
   output logic [7:0]       wr_byte,
   output logic [PTR_W-1:0] rd_idx,
   output logic             sda_pull
);

   localparam logic [7:0]       LAST_B = 8'(NUM_REGS - 1);
   localparam logic [PTR_W-1:0] LAST_P = PTR_W'(NUM_REGS - 1);

   rf_state_e        state_q;
   logic [2:0]       bit_q;
   logic [7:0]       shift_q;
   logic [7:0]       tx_q;
   logic [PTR_W-1:0] ptr_q;
   logic             pull_q;
   logic             dir_rd_q;
   logic             ack_half_q;

   logic [7:0]       byte_in;
   logic             byte_done;
   logic             bus_evt;
   logic             dev_hit;
   logic             base_ok;
   logic             base_load;
   logic [PTR_W-1:0] ptr_next;

   assign byte_in   = {shift_q[6:0], sda_lvl};
   assign byte_done = scl_rise && (bit_q == 3'd7);
   assign bus_evt   = start_det | stop_det;
   assign dev_hit   = (byte_in[7:1] == {DEV_ADDR_HI, strap_i});
   assign base_ok   = (byte_in <= LAST_B);
   assign ptr_next  = (ptr_q == LAST_P) ? ptr_q : ptr_q + PTR_W'(1);
   assign wr_en     = !bus_evt && (state_q == ST_WR) && byte_done;
   assign base_load = !bus_evt && (state_q == ST_BASE) && byte_done && base_ok;
   assign wr_idx    = ptr_q;
   assign wr_byte   = byte_in;
   assign rd_idx    = ptr_q;
   assign sda_pull  = pull_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         bit_q      <= '0;
         shift_q    <= '0;
         tx_q       <= '0;
         ptr_q      <= '0;
         pull_q     <= 1'b0;
         dir_rd_q   <= 1'b0;
         ack_half_q <= 1'b0;
      end else if (start_det) begin
         state_q    <= ST_DEV;
         bit_q      <= '0;
         pull_q     <= 1'b0;
         ack_half_q <= 1'b0;
      end else if (stop_det) begin
         state_q    <= ST_IDLE;
         bit_q      <= '0;
         pull_q     <= 1'b0;
         ack_half_q <= 1'b0;
      end else begin
         unique case (state_q)
            ST_DEV, ST_BASE, ST_WR: begin
               if (scl_rise) begin
                  shift_q <= byte_in;
                  bit_q   <= bit_q + 3'd1;
               end
               if (byte_done) begin
                  ack_half_q <= 1'b0;
                  if (state_q == ST_DEV) begin
                     if (dev_hit) begin
                        dir_rd_q <= byte_in[0];
                        state_q  <= ST_DEV_ACK;
                     end else begin
                        state_q  <= ST_SKIP;
                     end
                  end else if (state_q == ST_BASE) begin
                     if (base_ok) begin
                        ptr_q   <= byte_in[PTR_W-1:0];
                        state_q <= ST_BASE_ACK;
                     end else begin
                        state_q <= ST_SKIP;
                     end
                  end else begin
                     ptr_q   <= ptr_next;
                     state_q <= ST_WR_ACK;
                  end
               end
            end
            ST_DEV_ACK, ST_BASE_ACK, ST_WR_ACK: begin
               if (scl_fall) begin
                  if (!ack_half_q) begin
                     pull_q     <= 1'b1;
                     ack_half_q <= 1'b1;
                  end else begin
                     ack_half_q <= 1'b0;
                     bit_q      <= '0;
                     if (state_q == ST_DEV_ACK && dir_rd_q) begin
                        state_q <= ST_TX;
                        tx_q    <= rd_byte;
                        pull_q  <= ~rd_byte[7];
                     end else begin
                        pull_q  <= 1'b0;
                        state_q <= (state_q == ST_DEV_ACK) ? ST_BASE : ST_WR;
                     end
                  end
               end
            end
            ST_TX: begin
               if (scl_fall) begin
                  if (bit_q == 3'd7) begin
                     pull_q     <= 1'b0;
                     bit_q      <= '0;
                     ptr_q      <= ptr_next;
                     ack_half_q <= 1'b0;
                     state_q    <= ST_TX_ACK;
                  end else begin
                     tx_q   <= {tx_q[6:0], 1'b0};
                     pull_q <= ~tx_q[6];
                     bit_q  <= bit_q + 3'd1;
                  end
               end
            end
            ST_TX_ACK: begin
               if (!ack_half_q && scl_rise) begin
                  if (sda_lvl) state_q <= ST_SKIP;
                  else         ack_half_q <= 1'b1;
               end else if (ack_half_q && scl_fall) begin
                  ack_half_q <= 1'b0;
                  bit_q      <= '0;
                  tx_q       <= rd_byte;
                  pull_q     <= ~rd_byte[7];
                  state_q    <= ST_TX;
               end
            end
            default: begin
            end
         endcase
      end
   end

   // R5: the pointer stays inside the bank
   assert_ptr_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q <= LAST_P);

   // R4: besides a base load, the pointer only ever steps by one
   assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_q != $past(ptr_q)) && !$past(base_load) |-> ptr_q == $past(ptr_q) + PTR_W'(1));

   // R6: a refused base byte leaves the pointer where it was
   assert_badbase_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_BASE) && byte_done && !base_ok && !bus_evt |=> $stable(ptr_q));

   // R11: the pull enable moves only after SCL fell or on a bus condition
   assert_pull_on_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pull_q) |-> $past(scl_fall) || $past(start_det) || $past(stop_det));

   // R3: an unaddressed slave is silent and stores nothing
   assert_skip_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SKIP) |-> !pull_q && !wr_en);

   // R9: a master NACK on read releases the line
   assert_nack_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_TX_ACK) && !ack_half_q && scl_rise && sda_lvl && !bus_evt |=> !pull_q);

endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave #(
   parameter int         NUM_REGS    = 26,
   parameter int         SYNC_STAGES = 2,
   parameter logic [5:0] DEV_ADDR_HI = 6'b101101
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   input  logic                  addr_sel_i,
   output logic                  sda_pull_o,
   output logic [NUM_REGS*8-1:0] regs_o
);

   localparam int PTR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

   generate
      if (NUM_REGS < 2 || NUM_REGS > 256) begin : g_bad_depth
         $error("i2c_regfile_slave: NUM_REGS must lie in 2..256");
      end
   endgenerate

   logic             scl_rise;
   logic             scl_fall;
   logic             sda_lvl;
   logic             start_det;
   logic             stop_det;
   logic             wr_en;
   logic [PTR_W-1:0] wr_idx;
   logic [7:0]       wr_byte;
   logic [PTR_W-1:0] rd_idx;
   logic [7:0]       rd_byte;

   i2c_line_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .sda_lvl   (sda_lvl),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_regfile_fsm #(
      .NUM_REGS    (NUM_REGS),
      .PTR_W       (PTR_W),
      .DEV_ADDR_HI (DEV_ADDR_HI)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .strap_i   (addr_sel_i),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .sda_lvl   (sda_lvl),
      .start_det (start_det),
      .stop_det  (stop_det),
      .rd_byte   (rd_byte),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_byte   (wr_byte),
      .rd_idx    (rd_idx),
      .sda_pull  (sda_pull_o)
   );

   i2c_regfile_bank #(
      .NUM_REGS (NUM_REGS),
      .PTR_W    (PTR_W)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_byte   (wr_byte),
      .rd_idx    (rd_idx),
      .rd_byte   (rd_byte),
      .regs_flat (regs_o)
   );

endmodule

// File: tb/i2c_regfile_slave_tb.sv
module i2c_regfile_slave_tb;

   localparam int NREG = 26;
   localparam int LAST = NREG - 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            scl = 1'b1;
   logic            sda_m = 1'b1;
   logic            strap = 1'b0;
   logic            pull;
   logic            sda_bus;
   logic [NREG*8-1:0] regs;

   assign sda_bus = sda_m & ~pull;

   i2c_regfile_slave u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl),
      .sda_i      (sda_bus),
      .addr_sel_i (strap),
      .sda_pull_o (pull),
      .regs_o     (regs)
   );

   always #10 clk = ~clk;

   int nchk = 0;
   int nerr = 0;
   int tcount = 0;
   int cyc = 0;
   int mreg [NREG];
   int mptr = 0;
   int q_due[$];
   int q_addr[$];
   int q_data[$];
   logic prev_scl = 1'b1;
   logic prev_pull = 1'b0;
   bit   done = 0;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000 && !done) begin
         done = 1;
         nerr++;
         nchk++;
         $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, 190000);
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one clock of the reference model: due writes, bank compare, line rule
   task automatic tick();
      @(negedge clk);
      tcount++;
      while (q_due.size() > 0 && q_due[0] <= tcount) begin
         mreg[q_addr[0]] = q_data[0];
         void'(q_due.pop_front());
         void'(q_addr.pop_front());
         void'(q_data.pop_front());
      end
      begin
         int bad;
         bad = -1;
         for (int a = 0; a < NREG; a++)
            if (bad < 0 && int'(regs[a*8 +: 8]) != mreg[a]) bad = a;
         if (bad >= 0) check(0, $sformatf("R4 register model at %0d", bad), int'(regs[bad*8 +: 8]), mreg[bad]);
         else nchk++;
      end
      if (scl && prev_scl && pull != prev_pull)
         check(0, "R11 pull changed while SCL high", int'(pull), int'(prev_pull));
      else nchk++;
      prev_scl  = scl;
      prev_pull = pull;
   endtask

   task automatic ticks(input int n);
      repeat (n) tick();
   endtask

   task automatic bus_start();
      sda_m = 1'b1; ticks(4);
      scl = 1'b1;   ticks(4);
      sda_m = 1'b0; ticks(4);
      scl = 1'b0;   ticks(4);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; ticks(4);
      scl = 1'b1;   ticks(4);
      sda_m = 1'b1; ticks(8);
   endtask

   task automatic send_bit(input logic b, input bit push, input int wa, input int wd, output logic got);
      sda_m = b; ticks(4);
      scl = 1'b1;
      if (push) begin
         q_due.push_back(tcount + 3);
         q_addr.push_back(wa);
         q_data.push_back(wd);
      end
      ticks(4);
      got = sda_bus;
      ticks(4);
      scl = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] v, input bit wr_model, output bit acked);
      logic g;
      for (int i = 7; i >= 0; i--)
         send_bit(v[i], wr_model && (i == 0), mptr, int'(v), g);
      if (wr_model) mptr = (mptr < LAST) ? mptr + 1 : LAST;
      send_bit(1'b1, 0, 0, 0, g);
      acked = (g == 1'b0);
   endtask

   task automatic recv_byte(input bit m_ack, output logic [7:0] v);
      logic g;
      for (int i = 7; i >= 0; i--) begin
         sda_m = 1'b1; ticks(4);
         scl = 1'b1;   ticks(4);
         v[i] = sda_bus; ticks(4);
         scl = 1'b0;
      end
      mptr = (mptr < LAST) ? mptr + 1 : LAST;
      send_bit(!m_ack, 0, 0, 0, g);
   endtask

   task automatic wr_txn(input logic [7:0] dev, input int base, input int d[$], input string tag);
      bit a;
      bus_start();
      send_byte(dev, 0, a);          check(a, {tag, " device ack"}, int'(a), 1);
      send_byte(8'(base), 0, a);     check(a, {tag, " base ack"}, int'(a), 1);
      mptr = base;
      foreach (d[k]) begin
         send_byte(8'(d[k]), 1, a);  check(a, {tag, " data ack"}, int'(a), 1);
      end
      bus_stop();
   endtask

   task automatic rd_txn(input int base, input int e[$], input string tag);
      bit a;
      logic [7:0] v;
      bus_start();
      send_byte(8'hB4, 0, a);        check(a, {tag, " write-phase ack"}, int'(a), 1);
      send_byte(8'(base), 0, a);     check(a, {tag, " base ack"}, int'(a), 1);
      mptr = base;
      bus_start();
      send_byte(8'hB5, 0, a);        check(a, {tag, " read address ack"}, int'(a), 1);
      foreach (e[k]) begin
         recv_byte(k != e.size() - 1, v);
         check(int'(v) == e[k], {tag, " read data"}, int'(v), e[k]);
      end
      bus_stop();
   endtask

   initial begin
      bit a;
      logic [7:0] v;
      logic g;
      for (int i = 0; i < NREG; i++) mreg[i] = 0;
      ticks(5);
      rst_n = 1'b1;
      ticks(3);

      // R1: reset state
      check(regs == '0, "R1 registers after reset", int'(regs[7:0]), 0);
      check(pull == 1'b0, "R1 pull after reset", int'(pull), 0);

      // R2 R4: matched write, auto-increment
      wr_txn(8'hB4, 3, '{8'hA1, 8'hB2, 8'hC3}, "R4");
      check(regs[3*8 +: 8] == 8'hA1 && regs[5*8 +: 8] == 8'hC3, "R4 consecutive bytes", int'(regs[5*8 +: 8]), 'hC3);

      // R7: read via repeated start from the base
      rd_txn(3, '{8'hA1, 8'hB2, 8'hC3}, "R7");

      // R5: write saturation at the top register
      wr_txn(8'hB4, 'h17, '{8'h11, 8'h22, 8'h33, 8'h44}, "R5");
      check(regs[LAST*8 +: 8] == 8'h44, "R5 last register keeps final byte", int'(regs[LAST*8 +: 8]), 'h44);
      check(regs[24*8 +: 8] == 8'h22, "R5 register below top", int'(regs[24*8 +: 8]), 'h22);

      // R8: read saturation
      rd_txn('h18, '{8'h22, 8'h44, 8'h44, 8'h44}, "R8");

      // R6: out-of-range base refused, pointer kept
      wr_txn(8'hB4, 4, '{}, "R6 setup");
      bus_start();
      send_byte(8'hB4, 0, a);  check(a, "R6 device ack", int'(a), 1);
      send_byte(8'h1A, 0, a);  check(!a, "R6 base 0x1A not acked", int'(a), 0);
      send_byte(8'h77, 0, a);  check(!a, "R6 trailing byte not acked", int'(a), 0);
      bus_stop();
      bus_start();
      send_byte(8'hB5, 0, a);  check(a, "R7 read after fresh start ack", int'(a), 1);
      recv_byte(1, v);         check(v == 8'hB2, "R6 pointer unchanged first byte", int'(v), 'hB2);
      recv_byte(0, v);         check(v == 8'hC3, "R7 pointer advances", int'(v), 'hC3);
      bus_stop();

      // R3: address mismatch ignored
      bus_start();
      send_byte(8'hB6, 0, a);  check(!a, "R3 mismatch not acked", int'(a), 0);
      send_byte(8'h02, 0, a);  check(!a, "R3 ignored byte", int'(a), 0);
      send_byte(8'h99, 0, a);  check(!a, "R3 ignored byte 2", int'(a), 0);
      bus_stop();
      check(regs[2*8 +: 8] == 8'h00, "R3 register untouched", int'(regs[2*8 +: 8]), 0);

      // R2: strap selects address bit 0
      strap = 1'b1; ticks(4);
      wr_txn(8'hB6, 0, '{8'h5C}, "R2 strap high");
      bus_start();
      send_byte(8'hB4, 0, a);  check(!a, "R2 old address refused", int'(a), 0);
      bus_stop();
      strap = 1'b0; ticks(4);
      check(regs[7:0] == 8'h5C, "R2 write with strap high", int'(regs[7:0]), 'h5C);

      // R9: master NACK ends data, line released
      bus_start();
      send_byte(8'hB4, 0, a);  check(a, "R9 device ack", int'(a), 1);
      send_byte(8'h17, 0, a);  check(a, "R9 base ack", int'(a), 1);
      mptr = 'h17;
      bus_start();
      send_byte(8'hB5, 0, a);  check(a, "R9 read ack", int'(a), 1);
      recv_byte(0, v);         check(v == 8'h11, "R9 read data", int'(v), 'h11);
      for (int i = 7; i >= 0; i--) begin
         sda_m = 1'b1; ticks(4);
         scl = 1'b1;   ticks(4);
         v[i] = sda_bus; ticks(4);
         scl = 1'b0;
      end
      check(v == 8'hFF, "R9 line released after NACK", int'(v), 'hFF);
      bus_stop();

      // R10: start inside a byte
      bus_start();
      send_byte(8'hB4, 0, a);  check(a, "R10 device ack", int'(a), 1);
      send_byte(8'h08, 0, a);  check(a, "R10 base ack", int'(a), 1);
      mptr = 8;
      send_bit(1'b1, 0, 0, 0, g);
      send_bit(1'b0, 0, 0, 0, g);
      send_bit(1'b1, 0, 0, 0, g);
      bus_start();
      send_byte(8'hB4, 0, a);  check(a, "R10 address after restart", int'(a), 1);
      send_byte(8'h08, 0, a);  check(a, "R10 base after restart", int'(a), 1);
      mptr = 8;
      send_byte(8'h66, 1, a);  check(a, "R10 data after restart", int'(a), 1);
      bus_stop();
      check(regs[8*8 +: 8] == 8'h66, "R10 write after aborted byte", int'(regs[8*8 +: 8]), 'h66);

      // R10: stop inside a byte
      bus_start();
      send_byte(8'hB4, 0, a);  check(a, "R10 device ack 2", int'(a), 1);
      send_byte(8'h09, 0, a);  check(a, "R10 base ack 2", int'(a), 1);
      mptr = 9;
      for (int i = 0; i < 5; i++) send_bit(1'b1, 0, 0, 0, g);
      bus_stop();
      check(regs[9*8 +: 8] == 8'h00, "R10 partial byte not stored", int'(regs[9*8 +: 8]), 0);
      check(regs[4*8 +: 8] == 8'hB2, "R10 earlier register kept", int'(regs[4*8 +: 8]), 'hB2);
      rd_txn(8, '{8'h66, 8'h00}, "R10 bus usable after stop");

      ticks(10);
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule